// File: doc/BRIEF.md
# GPIO Input Glitch Qualifier (eight-pin group)

This block cleans up eight asynchronous general-purpose input pins before the rest of the chip sees them. Every raw pin first passes through a two-flop synchronizer. One programmable divider, shared by all eight pins, then produces a sample strobe. Each pin keeps a short history of its samples. The pin's qualified level moves to a new value only when the newest sample and the previous ones, three or six in total, all agree. Any pulse too short to fill that window is dropped.

Each pin can also be set to a synchronize-only mode. In that mode it skips qualification and follows the synchronized level one register later. The configuration arrives on plain input ports, and the qualified levels leave on plain output ports. The block moves levels and not transfers, so it has no valid/ready handshake and no back-pressure. Consumers may read the outputs on any cycle.

Top module: `gpio_qual_grp`

## Requirements
- R1: While `rst_n` is low, all eight `pin_q` bits are 0. The divider count and the sample histories are cleared.
- R2: With `qual_period` = 0 the group samples on every clock cycle. A 3-sample pin then rejects a 2-cycle pulse and passes a 3-cycle pulse.
- R3: With `qual_period` = n (1 to 255) the group samples once every 2×n cycles. At n=1 a 3-sample pin rejects a 3-cycle pulse and passes an 8-cycle pulse. At n=255 it rejects a 1020-cycle pulse and passes a 1600-cycle pulse. A new period value takes effect from the next strobe.
- R4: Bit i of `six_sel` picks the depth for pin i: 0 means 3 samples and 1 means 6 samples. At period 0, a 6-sample pin rejects 5 cycles and passes 6. At period 2 it rejects 20 cycles and passes 28. Pins with different depths are qualified independently in the same cycle.
- R5: A qualifying pin changes its output only on a strobe where all selected samples, newest included, equal the new level. Otherwise it holds its output. This holds for rising and falling pulses alike.
- R6: Bit i of `sync_only` set means pin i is not qualified. `pin_q[i]` equals `pin_raw[i]` delayed by exactly three clock edges, and even a 1-cycle pulse appears for one cycle.
- R7: Changing `qual_period` while the pins are steady never disturbs `pin_q`.
- R8: All qualifying pins share one strobe. A qualifying output changes only on a cycle where the strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 8 | Asynchronous raw pin levels |
| qual_period | input | 8 | Sampling period code: 0 means every cycle, n means every 2×n cycles |
| six_sel | input | 8 | Per pin: 1 = six samples, 0 = three samples |
| sync_only | input | 8 | Per pin: 1 = synchronize only, no qualification |
| pin_q | output | 8 | Qualified pin levels |

## Verification
The assertions check on every cycle that the strobe fires each cycle at period zero and that the divider restarts after each strobe. They also check that a qualifying output moves only on a strobe and only to the level just sampled, and that a synchronize-only output tracks the synchronized pin with one register of delay. The directed scenarios are needed for the rest. They show which pulse lengths are rejected or passed at each period and depth, that a new period takes effect, and that period changes cause no glitch. They also measure the exact three-edge latency of the bypass path.

// File: rtl/gq_pkg.sv
package gq_pkg;
  localparam int GQ_PINS      = 8;
  localparam int GQ_PERIOD_W  = 8;
  localparam int GQ_SHORT     = 3;
  localparam int GQ_LONG      = 6;
endpackage

// File: rtl/gq_sync.sv
module gq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= '0;
      d_sync <= '0;
    end else begin
      meta   <= d_async;
      d_sync <= meta;
    end
  end
endmodule

// File: rtl/gq_strobe.sv
module gq_strobe #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_in,
  output logic          stb
);
  localparam int CW = PW + 1;

  logic [PW-1:0] per_act;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    if (per_act == '0) limit = '0;
    else               limit = {per_act, 1'b0} - {{PW{1'b0}}, 1'b1};
  end

  assign stb = (cnt == limit);

  // The period is taken up only at a strobe, so a new value never cuts a window short.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_act <= '0;
    end else if (stb) begin
      cnt     <= '0;
      per_act <= period_in;
    end else begin
      cnt <= cnt + {{PW{1'b0}}, 1'b1};
    end
  end

  a_r2_zero_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act == '0) |-> stb);

  a_r3_restart_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (cnt == '0));
endmodule

// File: rtl/gq_filter.sv
module gq_filter #(
  parameter int SHORT = 3,
  parameter int LONG  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic smp,
  input  logic six_sel,
  input  logic bypass,
  output logic q
);
  localparam int HW = LONG - 1;

  logic [HW-1:0]    hist;
  logic [SHORT-1:0] win_s;
  logic [LONG-1:0]  win_l;
  logic             agree;

  assign win_s = {hist[SHORT-2:0], smp};
  assign win_l = {hist, smp};

  always_comb begin
    if (six_sel) agree = (&win_l) | ~(|win_l);
    else         agree = (&win_s) | ~(|win_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      q    <= 1'b0;
    end else begin
      if (stb) hist <= {hist[HW-2:0], smp};
      if (bypass)            q <= smp;
      else if (stb && agree) q <= smp;
    end
  end

  a_r8_change_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((q != $past(q)) && !$past(bypass)) |-> $past(stb));

  a_r5_moves_to_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ((q != $past(q)) && !$past(bypass)) |-> (q == $past(smp)));

  a_r6_bypass_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bypass) |-> (q == $past(smp)));
endmodule

// File: rtl/gpio_qual_grp.sv
module gpio_qual_grp
  import gq_pkg::*;
#(
  parameter int PINS     = GQ_PINS,
  parameter int PERIOD_W = GQ_PERIOD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PINS-1:0]     pin_raw,
  input  logic [PERIOD_W-1:0] qual_period,
  input  logic [PINS-1:0]     six_sel,
  input  logic [PINS-1:0]     sync_only,
  output logic [PINS-1:0]     pin_q
);
  logic [PINS-1:0] pin_s;
  logic            stb;

  gq_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_raw), .d_sync(pin_s)
  );

  gq_strobe #(.PW(PERIOD_W)) u_stb (
    .clk(clk), .rst_n(rst_n), .period_in(qual_period), .stb(stb)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gq_filter #(.SHORT(GQ_SHORT), .LONG(GQ_LONG)) u_flt (
      .clk(clk), .rst_n(rst_n), .stb(stb), .smp(pin_s[i]),
      .six_sel(six_sel[i]), .bypass(sync_only[i]), .q(pin_q[i])
    );
  end

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (pin_q == '0));
endmodule

// File: tb/sim_gpio_qual_grp.sv
module sim_gpio_qual_grp;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_raw = 8'h00;
  logic [7:0] qual_period = 8'h00;
  logic [7:0] six_sel = 8'h02;
  logic [7:0] sync_only = 8'h00;
  logic [7:0] pin_q;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_qual_grp u0 (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .qual_period(qual_period),
    .six_sel(six_sel), .sync_only(sync_only), .pin_q(pin_q)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Invert the masked pins for len cycles, then watch which outputs leave their base level.
  task automatic pulse_test(input logic [7:0] mask, input int len, input logic [7:0] exp_seen,
                            input int per, input string req);
    logic [7:0] base;
    logic [7:0] seen;
    int win;
    win  = 16 * (2 * per + 1) + 8;
    base = pin_q;
    seen = 8'h00;
    @(negedge clk);
    pin_raw = pin_raw ^ mask;
    for (int i = 0; i < len + win; i++) begin
      @(negedge clk);
      if (i == len - 1) pin_raw = pin_raw ^ mask;
      seen = seen | ((pin_q ^ base) & mask);
    end
    check(seen == exp_seen, req, seen, exp_seen);
    check(pin_q == base, {req, " settle"}, pin_q, base);
  endtask

  task automatic t_reset;
    pin_raw = 8'hA5;
    wait_cyc(4);
    check(pin_q == 8'h00, "R1 reset", pin_q, 8'h00);
    rst_n = 1'b1;
    wait_cyc(12);
    check(pin_q == 8'hA5, "R5 steady level accepted", pin_q, 8'hA5);
  endtask

  task automatic t_period_zero;
    qual_period = 8'd0;
    pulse_test(8'h01, 2, 8'h00, 0, "R2 low glitch 2 rejected");
    pulse_test(8'h01, 3, 8'h01, 0, "R2 low pulse 3 passed");
    pulse_test(8'h04, 2, 8'h00, 0, "R5 high glitch 2 rejected");
    pulse_test(8'h04, 3, 8'h04, 0, "R5 high pulse 3 passed");
  endtask

  task automatic t_depth;
    pulse_test(8'h03, 4, 8'h01, 0, "R4 mixed depth len4");
    pulse_test(8'h02, 5, 8'h00, 0, "R4 six rejects 5");
    pulse_test(8'h02, 6, 8'h02, 0, "R4 six passes 6");
  endtask

  task automatic t_period_n;
    qual_period = 8'd1;
    wait_cyc(8);
    pulse_test(8'h01, 3, 8'h00, 1, "R3 n1 rejects 3");
    pulse_test(8'h01, 8, 8'h01, 1, "R3 n1 passes 8");
    qual_period = 8'd2;
    wait_cyc(8);
    pulse_test(8'h02, 20, 8'h00, 2, "R4 n2 six rejects 20");
    pulse_test(8'h02, 28, 8'h02, 2, "R4 n2 six passes 28");
    qual_period = 8'd255;
    wait_cyc(8);
    pulse_test(8'h01, 1020, 8'h00, 255, "R3 n255 rejects 1020");
    pulse_test(8'h01, 1600, 8'h01, 255, "R3 n255 passes 1600");
    qual_period = 8'd0;
    wait_cyc(600);
    pulse_test(8'h01, 2, 8'h00, 0, "R3 reload to 0 rejects 2");
    pulse_test(8'h01, 3, 8'h01, 0, "R3 reload to 0 passes 3");
  endtask

  task automatic t_no_glitch;
    logic [7:0] bad;
    logic [7:0] ref_q;
    bad = 8'h00;
    ref_q = pin_q;
    for (int k = 0; k < 12; k++) begin
      qual_period = 8'((k * 53) % 7 == 0 ? 0 : (k * 53) % 200);
      for (int j = 0; j < 37; j++) begin
        @(negedge clk);
        bad = bad | (pin_q ^ ref_q);
      end
    end
    check(bad == 8'h00, "R7 period change no glitch", bad, 8'h00);
    qual_period = 8'd0;
    wait_cyc(600);
  endtask

  task automatic t_bypass;
    logic [7:0] base;
    logic [7:0] s1;
    logic [7:0] s2;
    logic [7:0] s3;
    logic [7:0] s4;
    sync_only = 8'h08;
    wait_cyc(4);
    base = pin_q;
    pin_raw = pin_raw ^ 8'h08;
    @(negedge clk); s1 = pin_q; pin_raw = pin_raw ^ 8'h08;
    @(negedge clk); s2 = pin_q;
    @(negedge clk); s3 = pin_q;
    @(negedge clk); s4 = pin_q;
    check(s1 == base, "R6 edge1 unchanged", s1, base);
    check(s2 == base, "R6 edge2 unchanged", s2, base);
    check(s3 == (base ^ 8'h08), "R6 edge3 pulse seen", s3, base ^ 8'h08);
    check(s4 == base, "R6 edge4 back", s4, base);
    sync_only = 8'h00;
    wait_cyc(8);
  endtask

  initial begin
    t_reset;
    t_period_zero;
    t_depth;
    t_period_n;
    t_no_glitch;
    t_bypass;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%02h expected=%02h", pin_q, pin_q);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule